// File: doc/BRIEF.md
# Hybrid Ternary Line Decoder

This block turns a stream of three-level line symbols back into binary data. Each symbol arrives as a two-bit code on `sym_in`, qualified by the one-cycle strobe `sym_stb`. It is already aligned to the bit period. A positive or negative symbol carries its bit value directly. A zero-level symbol carries no value by itself: it repeats the bit decoded just before it. The block therefore holds the decode history in a small state machine.

The same history lets the block spot symbol pairs that the matching encoder can never emit. The encoder never sends the same level twice in a row. It also never sends the code `2'b11`. Either event pulses `code_err` for the result cycle of that strobe.

The history machine has five states:

| State | Meaning |
|---|---|
| `ST_FRESH` | Nothing received since reset; the remembered bit is 0. |
| `ST_POS` | The last accepted symbol was positive; the remembered bit is 1. |
| `ST_NEG` | The last accepted symbol was negative; the remembered bit is 0. |
| `ST_ZERO_HI` | The last accepted symbol was zero; the remembered bit is 1. |
| `ST_ZERO_LO` | The last accepted symbol was zero; the remembered bit is 0. |

Its transitions, taken only on a strobe, are:

| Transition | Taken when | Effect |
|---|---|---|
| `ANY -> ST_POS` | a positive symbol is accepted | `code_err` is raised if the state was already `ST_POS` |
| `ANY -> ST_NEG` | a negative symbol is accepted | `code_err` is raised if the state was already `ST_NEG` |
| `ANY -> ST_ZERO_HI` or `ST_ZERO_LO` | a zero symbol is accepted | the target follows the remembered bit; `code_err` is raised if the state was already a zero state |
| `ANY -> same` | the code `2'b11` arrives | the state is held and `code_err` is raised |

Top module: `htern_rx_decoder`

## Requirements
- R1: Synchronous active-high reset clears `bit_out`, `bit_vld` and `code_err` to 0 and forgets all history. The first symbol after reset never raises `code_err`, and a leading zero symbol decodes as 0.
- R2: A strobed positive symbol (`2'b10`) decodes to 1, whatever came before.
- R3: A strobed negative symbol (`2'b01`) decodes to 0, whatever came before.
- R4: A strobed zero symbol (`2'b00`) decodes to the previously decoded bit.
- R5: A strobed code `2'b11` raises `code_err` with `bit_vld` low. It leaves `bit_out` and the decode history unchanged, so the next symbol is judged against the symbol before the bad code.
- R6: Two consecutive positive symbols, or two consecutive negative symbols, raise `code_err`. The second symbol is still decoded normally with `bit_vld` high.
- R7: Two consecutive zero symbols raise `code_err`. The second zero still decodes to the previous bit with `bit_vld` high.
- R8: Results are registered and appear on the clock edge that follows the strobe cycle, which is one bit period; a one-period encoder in front gives two periods end to end. Back-to-back strobes are accepted. `bit_vld` and `code_err` are single-cycle pulses. In cycles without a strobe, both stay low and `bit_out` holds.
- R9: A random bit stream coded by the matching encoder, starting from the zero level, is reproduced bit for bit with `code_err` never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | Symbol strobe, one cycle per bit period |
| sym_in | input | 2 | Line symbol: `2'b10` positive, `2'b00` zero, `2'b01` negative, `2'b11` illegal |
| bit_out | output | 1 | Last decoded bit, held between strobes |
| bit_vld | output | 1 | Pulses when `bit_out` was updated by the preceding strobe |
| code_err | output | 1 | Pulses when the preceding strobe carried an illegal code or an illegal successor |

## Verification
The embedded properties check, on every cycle, the decoding of each symbol kind, the zero-symbol hold rule, and the response to the illegal code. They also check that nothing happens between strobes and that the history holds over bad codes and repeated zeros. Only the bench scenarios can show the longer effects. One is that a bad code hides itself from the following legality check. Another is a full encoded random stream decoding without a single false violation. A third is the reset rule for a leading zero, which needs a chosen sequence rather than a cycle-local relation.

// File: rtl/htern_rx_pkg.sv
package htern_rx_pkg;

    localparam int SYM_W = 2;

    // Line symbol codes
    typedef enum logic [SYM_W-1:0] {
        LVL_ZERO = 2'b00,
        LVL_NEG  = 2'b01,
        LVL_POS  = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_e;

    // Decode history: last accepted level plus remembered bit
    typedef enum logic [2:0] {
        ST_FRESH   = 3'd0,
        ST_POS     = 3'd1,
        ST_ZERO_HI = 3'd2,
        ST_ZERO_LO = 3'd3,
        ST_NEG     = 3'd4
    } hist_e;

    typedef struct packed {
        logic bit_val;
        logic vld;
        logic err;
    } dec_s;

    function automatic logic hist_bit(input hist_e s);
        return (s == ST_POS) || (s == ST_ZERO_HI);
    endfunction

    function automatic logic hist_is_zero(input hist_e s);
        return (s == ST_ZERO_HI) || (s == ST_ZERO_LO);
    endfunction

endpackage

// File: rtl/htern_sym_class.sv
module htern_sym_class
    import htern_rx_pkg::*;
(
    input  logic [SYM_W-1:0] sym_in,
    input  logic             sym_stb,
    output lvl_e             lvl,
    output logic             take
);
    always_comb begin
        lvl  = lvl_e'(sym_in);
        take = sym_stb;
    end
endmodule

// File: rtl/htern_hist_fsm.sv
module htern_hist_fsm
    import htern_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  lvl_e  lvl,
    output hist_e cur,
    output dec_s  dec
);
    hist_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FRESH;
        else     cur <= nxt;
    end

    // Next state and decode decision
    always_comb begin
        nxt         = cur;
        dec.bit_val = hist_bit(cur);
        dec.vld     = 1'b0;
        dec.err     = 1'b0;
        if (take) begin
            unique case (lvl)
                LVL_BAD: begin
                    dec.err = 1'b1;
                end
                LVL_POS: begin
                    dec.vld     = 1'b1;
                    dec.bit_val = 1'b1;
                    dec.err     = (cur == ST_POS);
                    nxt         = ST_POS;
                end
                LVL_NEG: begin
                    dec.vld     = 1'b1;
                    dec.bit_val = 1'b0;
                    dec.err     = (cur == ST_NEG);
                    nxt         = ST_NEG;
                end
                LVL_ZERO: begin
                    dec.vld     = 1'b1;
                    dec.bit_val = hist_bit(cur);
                    dec.err     = hist_is_zero(cur);
                    nxt         = hist_bit(cur) ? ST_ZERO_HI : ST_ZERO_LO;
                end
            endcase
        end
    end

    // R5
    bad_keeps_hist_chk: assert property (@(posedge clk) disable iff (rst)
        (take && lvl == LVL_BAD) |=> $stable(cur));

    // R7
    zero_repeat_hist_chk: assert property (@(posedge clk) disable iff (rst)
        (take && lvl == LVL_ZERO && hist_is_zero(cur)) |=> $stable(cur));

    // R6
    pos_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (take && lvl == LVL_POS) |=> (cur == ST_POS));

    // R8
    idle_hist_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(cur));
endmodule

// File: rtl/htern_out_stage.sv
module htern_out_stage
    import htern_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  dec_s dec,
    output logic bit_q,
    output logic vld_q,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= dec.vld;
            err_q <= dec.err;
            if (dec.vld) bit_q <= dec.bit_val;
        end
    end

    // R8
    hold_without_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !dec.vld |=> $stable(bit_q));
endmodule

// File: rtl/htern_rx_decoder.sv
module htern_rx_decoder
    import htern_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_stb,
    input  logic [1:0] sym_in,
    output logic       bit_out,
    output logic       bit_vld,
    output logic       code_err
);
    lvl_e  lvl;
    logic  take;
    hist_e hist;
    dec_s  dec;

    htern_sym_class u_class (
        .sym_in (sym_in),
        .sym_stb(sym_stb),
        .lvl    (lvl),
        .take   (take)
    );

    htern_hist_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .take(take),
        .lvl (lvl),
        .cur (hist),
        .dec (dec)
    );

    htern_out_stage u_out (
        .clk  (clk),
        .rst  (rst),
        .dec  (dec),
        .bit_q(bit_out),
        .vld_q(bit_vld),
        .err_q(code_err)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!bit_out && !bit_vld && !code_err));

    // R2
    pos_one_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && sym_in == 2'b10) |=> (bit_vld && bit_out));

    // R3
    neg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && sym_in == 2'b01) |=> (bit_vld && !bit_out));

    // R4
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && sym_in == 2'b00) |=> (bit_vld && bit_out == $past(bit_out)));

    // R5
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && sym_in == 2'b11) |=> (code_err && !bit_vld && $stable(bit_out)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_stb |=> (!bit_vld && !code_err && $stable(bit_out)));
endmodule

// File: tb/htern_rx_decoder_tb_top.sv
module htern_rx_decoder_tb_top;

    typedef struct {
        logic  b;
        logic  v;
        logic  e;
        string rq;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_stb = 1'b0;
    logic [1:0] sym_in = 2'b00;
    logic       bit_out, bit_vld, code_err;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    // Requirement model: hist 0 fresh, 1 pos, 2 zero, 3 neg
    int   m_hist = 0;
    logic m_bit  = 1'b0;
    // Reference encoder level: 0 zero, 1 pos, 2 neg
    int   enc_lvl = 0;

    always #4 clk = ~clk;

    htern_rx_decoder dut_i (
        .clk     (clk),
        .rst     (rst),
        .sym_stb (sym_stb),
        .sym_in  (sym_in),
        .bit_out (bit_out),
        .bit_vld (bit_vld),
        .code_err(code_err)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual b/v/e=%b expected %b", rq, what, act, exp);
        end
    endtask

    task automatic predict(input logic [1:0] s, output exp_t e);
        e.e = 1'b0;
        e.v = 1'b1;
        case (s)
            2'b11: begin e.v = 1'b0; e.e = 1'b1; end
            2'b10: begin e.e = (m_hist == 1); m_bit = 1'b1; m_hist = 1; end
            2'b01: begin e.e = (m_hist == 3); m_bit = 1'b0; m_hist = 3; end
            default: begin e.e = (m_hist == 2); m_hist = 2; end
        endcase
        e.b = m_bit;
    endtask

    task automatic push_drive(input exp_t e, input logic [1:0] s, input int gap);
        q.push_back(e);
        @(negedge clk);
        sym_stb = 1'b1;
        sym_in  = s;
        if (gap > 0) begin
            @(negedge clk);
            sym_stb = 1'b0;
            sym_in  = 2'b00;
            repeat (gap - 1) @(negedge clk);
        end
    endtask

    task automatic send(input logic [1:0] s, input string rq, input int gap);
        exp_t e;
        predict(s, e);
        e.rq = rq;
        push_drive(e, s, gap);
    endtask

    // R9: encode one bit and expect exactly that bit back without error
    task automatic send_bit(input logic b, input int gap);
        exp_t e;
        logic [1:0] s;
        if (b) begin
            if (enc_lvl == 1) begin s = 2'b00; enc_lvl = 0; end
            else              begin s = 2'b10; enc_lvl = 1; end
        end else begin
            if (enc_lvl == 2) begin s = 2'b00; enc_lvl = 0; end
            else              begin s = 2'b01; enc_lvl = 2; end
        end
        predict(s, e);
        e.b  = b;
        e.v  = 1'b1;
        e.e  = 1'b0;
        e.rq = "R9";
        push_drive(e, s, gap);
    endtask

    task automatic finish_sends();
        @(negedge clk);
        sym_stb = 1'b0;
        sym_in  = 2'b00;
        repeat (3) @(negedge clk);
    endtask

    // R8: no strobe means no pulses and a held bit
    task automatic check_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!bit_vld && !code_err && bit_out == m_bit, "R8", "idle",
                {bit_out, bit_vld, code_err}, {m_bit, 2'b00});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst     = 1'b1;
        sym_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst     = 1'b0;
        m_hist  = 0;
        m_bit   = 1'b0;
        enc_lvl = 0;
    endtask

    // Monitor: compare one clock after each strobe
    initial forever begin
        exp_t e;
        @(posedge clk);
        if (!rst && sym_stb === 1'b1) begin
            @(negedge clk);
            if (q.size() == 0) begin
                chk(1'b0, "R8", "unexpected result", {bit_out, bit_vld, code_err}, 3'b000);
            end else begin
                e = q.pop_front();
                chk(bit_out === e.b && bit_vld === e.v && code_err === e.e, e.rq, "decode",
                    {bit_out, bit_vld, code_err}, {e.b, e.v, e.e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected done");
        report();
        $finish;
    end

    initial begin
        logic [6:0] lfsr;
        logic       pb;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bit_out && !bit_vld && !code_err, "R1", "reset state",
            {bit_out, bit_vld, code_err}, 3'b000);
        rst = 1'b0;
        // R1 leading zero decodes as 0, no violation
        send(2'b00, "R1", 1);
        send(2'b10, "R2", 1);
        check_idle(3);

        // R2 / R3 / R4 over different histories
        do_reset();
        send(2'b01, "R3", 0);
        send(2'b00, "R4", 0);
        send(2'b10, "R2", 0);
        send(2'b00, "R4", 0);
        send(2'b01, "R3", 0);
        send(2'b10, "R2", 2);
        check_idle(2);

        // R5 bad code keeps history: + , 11, 0 -> decodes 1, no error
        send(2'b11, "R5", 1);
        send(2'b00, "R5", 1);
        // + after bad code after zero: legal
        send(2'b11, "R5", 0);
        send(2'b10, "R5", 1);
        // bad code right after another + must not hide repeat: + 11 + -> error
        send(2'b11, "R5", 0);
        send(2'b10, "R6", 1);

        // R6 repeated nonzero levels
        send(2'b10, "R6", 0);
        send(2'b01, "R3", 0);
        send(2'b01, "R6", 0);
        // R7 repeated zero
        send(2'b00, "R4", 0);
        send(2'b00, "R7", 0);
        send(2'b10, "R2", 0);
        send(2'b00, "R4", 0);
        send(2'b00, "R7", 1);
        check_idle(2);

        // R9 patterns: alternating, runs of ones and zeros, then PN data
        do_reset();
        for (int i = 0; i < 8; i++) send_bit(i[0], 0);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 0);
        for (int i = 0; i < 7; i++) send_bit(1'b0, 1);
        lfsr = 7'h5B;
        for (int i = 0; i < 254; i++) begin
            pb   = lfsr[6];
            lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
            send_bit(pb, {30'd0, lfsr[1:0] == 2'b11});
        end
        finish_sends();
        chk(q.size() == 0, "R8", "queue drained", {2'b00, q.size() != 0}, 3'b000);

        report();
        $finish;
    end

endmodule